// File: doc/BRIEF.md
# LCD Drive Level Sequencer

This block produces the drive waveforms for a multiplexed liquid-crystal panel as two-bit level codes. There is one code per common line and one per segment line. An analog stage outside the block turns each code into one of four voltages: the ground rail VSS, or one of the bias levels V1, V2 and V3. The block scans the common lines one slot at a time. It flips an alternation flag at every frame wrap, so that each frame is followed by its mirror image and the panel sees no net DC. It supports static drive and the 1/2, 1/3 and 1/4 multiplex ratios.

A programmable prescaler sets the slot rate. It counts single-cycle tick pulses from one of two sources: a fast main clock, divided by a power of two, or a slow subclock, taken directly or halved. The block also takes an enable, a power-mode code and a bias-divider switch request. From these it decides whether the display may run and whether the resistive bias divider may be switched on. When the display is stopped, every line rests at VSS and the scan restarts from the first slot.

Top module: `lcd_level_seq`

## Requirements
- R1: Level codes are VSS=0, V1=1, V2=2, V3=3. Common c uses bits [2c+1:2c] of `com_lvl` and segment s uses bits [2s+1:2s] of `seg_lvl`. In static drive (`duty_sel`=0), common 0 shows V1 while M=0 and VSS while M=1, whatever its data. A segment shows V1 when its data bit equals M and VSS when they differ.
- R2: At 1/2 duty (`duty_sel`=1), an unselected active common shows V2 for both values of M. The selected common shows V1 for M=0 and VSS for M=1. Segments follow the R1 mapping.
- R3: At 1/3 and 1/4 duty (`duty_sel`=2 or 3), a common shows V3, V2, V1 or VSS for (selected, M) = (0,0), (0,1), (1,0) or (1,1). A segment shows V2, V3, VSS or V1 for (data, M) in the same order.
- R4: The active line count N is `duty_sel`+1. The slot index advances by one on each prescaler step and wraps from N-1 to 0. Common c is selected in slot c. Commons with index N or higher stay at VSS. In every slot, the data bit for segment s is `seg_data[s*4+slot]`.
- R5: M (`m_out`) flips on each step that wraps the slot index. In static drive it therefore flips on every step.
- R6: With `cks` 0 to 13, one step occurs every 2^cks `main_tick` pulses. With `cks`=14, one step occurs on every `sub_tick` pulse, and with `cks`=15 on every second `sub_tick` pulse. Pulses from the source that is not selected have no effect.
- R7: With `act`=0, the display is stopped in every power mode.
- R8: In watch (`pwr_mode`=3), subactive (4) and subsleep (5), the display runs only if `act`=1 and `cks` is 14 or 15.
- R9: In reset (`pwr_mode`=0) and standby (6), the display is stopped and `div_en` is 0 whatever `psw` is. In modes 1 to 5, `div_en` equals `psw`.
- R10: In active (`pwr_mode`=1) and sleep (2) with `act`=1, the display runs from any `cks` setting.
- R11: While stopped, all commons and segments show VSS and `m_out` is 0. After the first clock edge of a stop, the slot, M and prescaler count are all cleared, so a restart begins at slot 0 with M=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_sel | input | 2 | Multiplex ratio: 0 static, 1 half, 2 third, 3 quarter |
| act | input | 1 | Display enable |
| cks | input | 4 | Slot-rate source and divider select |
| pwr_mode | input | 3 | Power mode code |
| psw | input | 1 | Bias divider switch request |
| main_tick | input | 1 | One-cycle pulse per main clock period |
| sub_tick | input | 1 | One-cycle pulse per subclock period |
| seg_data | input | NUM_SEG*4 | Segment pattern, bit s*4+c for segment s in slot c |
| com_lvl | output | 8 | Level codes of the four common lines |
| seg_lvl | output | NUM_SEG*2 | Level codes of the segment lines |
| m_out | output | 1 | Alternation flag M |
| div_en | output | 1 | Bias divider enable |

## Verification
The assertions assume that `cks` and `duty_sel` do not change while the display is running. A change of divider in mid-count could legally shorten a step interval, and the one-step-per-interval check does not allow for that. They also assume that the tick inputs are single-cycle pulses. The bench keeps to these assumptions: it changes configuration only after dropping `act` for a cycle, and it drives each tick as a pulse from one falling edge to the next.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int NUM_COM = 4;
    localparam int SLOT_W  = 2;

    localparam logic [3:0] CKS_SUB_DIV1 = 4'hE;
    localparam logic [3:0] CKS_SUB_DIV2 = 4'hF;

    typedef enum logic [1:0] {
        LV_VSS = 2'd0,
        LV_V1  = 2'd1,
        LV_V2  = 2'd2,
        LV_V3  = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        DUTY_STATIC  = 2'd0,
        DUTY_HALF    = 2'd1,
        DUTY_THIRD   = 2'd2,
        DUTY_QUARTER = 2'd3
    } duty_e;

    typedef enum logic [2:0] {
        PM_RESET    = 3'd0,
        PM_ACTIVE   = 3'd1,
        PM_SLEEP    = 3'd2,
        PM_WATCH    = 3'd3,
        PM_SUBACT   = 3'd4,
        PM_SUBSLEEP = 3'd5,
        PM_STANDBY  = 3'd6,
        PM_RSVD     = 3'd7
    } pmode_e;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              m;
    } scan_t;

    function automatic logic [2:0] duty_lines(duty_e d);
        return 3'(d) + 3'd1;
    endfunction

    function automatic logic is_sub_sel(logic [3:0] cks);
        return (cks == CKS_SUB_DIV1) || (cks == CKS_SUB_DIV2);
    endfunction

    function automatic lvl_e com_level(duty_e d, logic sel, logic m);
        lvl_e r;
        case (d)
            DUTY_STATIC: r = m ? LV_VSS : LV_V1;
            DUTY_HALF:   r = !sel ? LV_V2 : (m ? LV_VSS : LV_V1);
            default:     r = sel ? (m ? LV_VSS : LV_V1) : (m ? LV_V2 : LV_V3);
        endcase
        return r;
    endfunction

    function automatic lvl_e seg_level(duty_e d, logic on, logic m);
        lvl_e r;
        if (d == DUTY_STATIC || d == DUTY_HALF)
            r = (on == m) ? LV_V1 : LV_VSS;
        else
            r = on ? (m ? LV_V1 : LV_VSS) : (m ? LV_V3 : LV_V2);
        return r;
    endfunction

endpackage

// File: rtl/lcd_prescaler.sv
module lcd_prescaler
    import lcd_seq_pkg::*;
#(
    parameter int PRE_W = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic [3:0] cks,
    input  logic       main_tick,
    input  logic       sub_tick,
    output logic       step
);
    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] last;
    logic             tick;
    logic             sub_sel;

    assign sub_sel = is_sub_sel(cks);
    assign tick    = sub_sel ? sub_tick : main_tick;

    always_comb begin
        if (sub_sel)
            last = (cks == CKS_SUB_DIV2) ? PRE_W'(1) : '0;
        else
            last = (PRE_W'(1) << cks) - PRE_W'(1);
    end

    assign step = !clr && tick && (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt >= last) ? '0 : cnt + PRE_W'(1);
    end

    // R6
    step_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (step && last != '0) |=> !step);

    // R11
    pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);

endmodule

// File: rtl/lcd_scan_ctr.sv
module lcd_scan_ctr
    import lcd_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  step,
    input  duty_e duty,
    output scan_t st
);
    logic wrap;

    assign wrap = ({1'b0, st.slot} >= (duty_lines(duty) - 3'd1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st <= '0;
        end else if (step) begin
            if (wrap) begin
                st.slot <= '0;
                st.m    <= !st.m;
            end else begin
                st.slot <= st.slot + SLOT_W'(1);
            end
        end
    end

    // R4
    slot_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && !wrap) |=> st.slot == $past(st.slot) + SLOT_W'(1));

    // R5
    m_flip_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(st.m) |-> ($past(step && wrap) || $past(clr)));

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run,
    input  duty_e                      duty,
    input  scan_t                      st,
    input  logic [NUM_SEG*NUM_COM-1:0] seg_data,
    output logic [NUM_COM*2-1:0]       com_lvl,
    output logic [NUM_SEG*2-1:0]       seg_lvl
);
    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        logic in_use;
        logic sel;
        lvl_e lv;
        assign in_use = (3'(c) < duty_lines(duty));
        assign sel    = (st.slot == SLOT_W'(c));
        assign lv     = (run && in_use) ? com_level(duty, sel, st.m) : LV_VSS;
        assign com_lvl[2*c +: 2] = lv;

        // R2
        half_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (run && duty == DUTY_HALF && in_use && !sel) |-> com_lvl[2*c +: 2] == LV_V2);
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [NUM_COM-1:0] row;
        lvl_e lv;
        assign row = seg_data[s*NUM_COM +: NUM_COM];
        assign lv  = run ? seg_level(duty, row[st.slot], st.m) : LV_VSS;
        assign seg_lvl[2*s +: 2] = lv;
    end

endmodule

// File: rtl/lcd_level_seq.sv
module lcd_level_seq
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG = 8,
    parameter int PRE_W   = 14
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 duty_sel,
    input  logic                       act,
    input  logic [3:0]                 cks,
    input  logic [2:0]                 pwr_mode,
    input  logic                       psw,
    input  logic                       main_tick,
    input  logic                       sub_tick,
    input  logic [NUM_SEG*NUM_COM-1:0] seg_data,
    output logic [NUM_COM*2-1:0]       com_lvl,
    output logic [NUM_SEG*2-1:0]       seg_lvl,
    output logic                       m_out,
    output logic                       div_en
);
    pmode_e pm;
    duty_e  duty;
    logic   clk_ok;
    logic   run;
    logic   step;
    scan_t  st;

    assign pm   = pmode_e'(pwr_mode);
    assign duty = duty_e'(duty_sel);

    always_comb begin
        case (pm)
            PM_ACTIVE, PM_SLEEP:               clk_ok = 1'b1;
            PM_WATCH, PM_SUBACT, PM_SUBSLEEP:  clk_ok = is_sub_sel(cks);
            default:                           clk_ok = 1'b0;
        endcase
    end

    assign run    = act && clk_ok;
    assign div_en = psw && (pm != PM_RESET) && (pm != PM_STANDBY) && (pm != PM_RSVD);
    assign m_out  = run && st.m;

    lcd_prescaler #(.PRE_W(PRE_W)) pre_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (!run),
        .cks       (cks),
        .main_tick (main_tick),
        .sub_tick  (sub_tick),
        .step      (step)
    );

    lcd_scan_ctr scan_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (!run),
        .step (step),
        .duty (duty),
        .st   (st)
    );

    lcd_level_map #(.NUM_SEG(NUM_SEG)) map_i (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .duty     (duty),
        .st       (st),
        .seg_data (seg_data),
        .com_lvl  (com_lvl),
        .seg_lvl  (seg_lvl)
    );

    // R9
    div_off_chk: assert property (@(posedge clk) disable iff (rst)
        (pm == PM_RESET || pm == PM_STANDBY) |-> !div_en);

    // R11
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (st.slot == '0 && !st.m));

    // R8
    sub_only_chk: assert property (@(posedge clk) disable iff (rst)
        ((pm == PM_WATCH || pm == PM_SUBACT || pm == PM_SUBSLEEP) && !is_sub_sel(cks))
        |-> (com_lvl == '0 && seg_lvl == '0 && !m_out));

    // R7
    act_off_chk: assert property (@(posedge clk) disable iff (rst)
        !act |-> (com_lvl == '0 && seg_lvl == '0));

endmodule

// File: tb/lcd_level_seq_tb_top.sv
module lcd_level_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSEG = 8;
    localparam int NC   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        duty_sel = 2'd0;
    logic              act = 1'b0;
    logic [3:0]        cks = 4'd14;
    logic [2:0]        pwr_mode = 3'd1;
    logic              psw = 1'b1;
    logic              main_tick = 1'b0;
    logic              sub_tick = 1'b0;
    logic [NSEG*NC-1:0] seg_data = '0;
    logic [NC*2-1:0]   com_lvl;
    logic [NSEG*2-1:0] seg_lvl;
    logic              m_out;
    logic              div_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    bit exp_run = 0;
    int k = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_level_seq #(.NUM_SEG(NSEG)) dut_i (
        .clk(clk), .rst(rst), .duty_sel(duty_sel), .act(act), .cks(cks),
        .pwr_mode(pwr_mode), .psw(psw), .main_tick(main_tick), .sub_tick(sub_tick),
        .seg_data(seg_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
        .m_out(m_out), .div_en(div_en)
    );

    function automatic int e_com(int d, bit sel, bit m);
        if (d == 0) return m ? 0 : 1;
        if (d == 1) return !sel ? 2 : (m ? 0 : 1);
        if (sel) return m ? 0 : 1;
        return m ? 2 : 3;
    endfunction

    function automatic int e_seg(int d, bit on, bit m);
        if (d <= 1) return (on == m) ? 1 : 0;
        if (on) return m ? 1 : 0;
        return m ? 3 : 2;
    endfunction

    task automatic cmp(string req, int act_v, int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
        end
    endtask

    task automatic check_all(string req);
        int n, slot;
        bit m;
        #1;
        n    = int'(duty_sel) + 1;
        slot = k % n;
        m    = ((k / n) % 2) == 1;
        for (int c = 0; c < NC; c++) begin
            int e;
            e = (exp_run && c < n) ? e_com(int'(duty_sel), c == slot, m) : 0;
            cmp({req, " com"}, int'(com_lvl[2*c +: 2]), e);
        end
        for (int s = 0; s < NSEG; s++) begin
            int e;
            e = exp_run ? e_seg(int'(duty_sel), seg_data[s*NC + slot], m) : 0;
            cmp({req, " seg"}, int'(seg_lvl[2*s +: 2]), e);
        end
        cmp({req, " m_out"}, int'(m_out), int'(exp_run && m));
        cmp({req, " div_en"}, int'(div_en),
            int'(psw && pwr_mode >= 3'd1 && pwr_mode <= 3'd5));
    endtask

    task automatic pulse_sub();
        @(negedge clk) sub_tick = 1'b1;
        @(negedge clk) sub_tick = 1'b0;
    endtask

    task automatic pulse_main();
        @(negedge clk) main_tick = 1'b1;
        @(negedge clk) main_tick = 1'b0;
    endtask

    task automatic restart(int d, int c, int pm);
        @(negedge clk) act = 1'b0;
        @(negedge clk);
        duty_sel = 2'(d); cks = 4'(c); pwr_mode = 3'(pm); act = 1'b1;
        k = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        exp_run = 0;
        check_all("R11 reset state");

        // R1 R2 R3 R4 R5: sweep every duty with subclock direct
        for (int d = 0; d < 4; d++) begin
            restart(d, 14, 1);
            exp_run = 1;
            seg_data = $urandom;
            check_all(d == 0 ? "R1 start" : (d == 1 ? "R2 start" : "R3 start"));
            for (int i = 0; i < 4 * (d + 1) + 1; i++) begin
                seg_data = $urandom;
                pulse_sub();
                k++;
                check_all(d == 0 ? "R1 R5 step" : (d == 1 ? "R2 R4 step" : "R3 R4 step"));
            end
            // R6: main ticks ignored while subclock selected
            pulse_main();
            check_all("R6 unselected source");
        end

        // R6: main divider 2^2
        restart(3, 2, 1);
        for (int i = 0; i < 3; i++) begin
            pulse_main();
            check_all("R6 main hold");
        end
        pulse_main(); k++;
        check_all("R6 main step");
        pulse_sub();
        check_all("R6 sub ignored");

        // R6: subclock halved
        restart(2, 15, 1);
        pulse_sub();
        check_all("R6 sub half hold");
        pulse_sub(); k++;
        check_all("R6 sub half step");

        // R8: subclock-only modes
        for (int pm = 3; pm <= 5; pm++) begin
            restart(3, 0, pm);
            exp_run = 0;
            pulse_main(); pulse_sub();
            check_all("R8 main selected stop");
            restart(3, 14, pm);
            exp_run = 1;
            pulse_sub(); k++;
            check_all("R8 sub run");
        end

        // R10: sleep with main divider 2^1
        restart(1, 1, 2);
        exp_run = 1;
        pulse_main(); pulse_main(); k++;
        check_all("R10 sleep main");

        // R9: reset and standby modes with psw high
        restart(2, 14, 0);
        exp_run = 0;
        pulse_sub();
        check_all("R9 reset mode");
        restart(2, 14, 6);
        pulse_sub();
        check_all("R9 standby mode");
        restart(2, 14, 1);
        psw = 1'b0;
        exp_run = 1;
        check_all("R9 psw low");
        psw = 1'b1;

        // R7: act low in active mode
        @(negedge clk) act = 1'b0;
        exp_run = 0;
        pulse_sub();
        check_all("R7 act off");

        // R11: stop mid-frame restarts at slot 0, M 0
        restart(2, 14, 1);
        exp_run = 1;
        seg_data = $urandom;
        for (int i = 0; i < 5; i++) begin pulse_sub(); k++; end
        check_all("R11 pre-stop");
        @(negedge clk) act = 1'b0;
        exp_run = 0;
        check_all("R11 stopped");
        @(negedge clk) act = 1'b1;
        exp_run = 1; k = 0;
        check_all("R11 restart");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule